// File: doc/BRIEF.md
# Double-Latched Programmable Feedback Divider

This block is the feedback divider of a frequency synthesizer. It is a 15-bit presettable down counter clocked by the prescaled oscillator signal. Each time the counter reaches zero it emits a one-clock output pulse and reloads itself from a holding register. The pulse stream therefore runs at the input frequency divided by the programmed ratio.

A new ratio is written into a staging register at any time. The staging value moves into the holding register only at the counter's reload moment, or when a start event arrives from the serial control bus. Because of this, a write never disturbs a period that is already in progress. The bus-start line is asynchronous. It passes through a two-flop synchronizer and a rising-edge detector before it can trigger a transfer. A ratio below the minimum of 17 is raised to 17 when it is transferred. After reset the ratio is 256. A second output toggles at every pulse, which gives the divided signal divided by two for test use.

Top module: `ratio_divider`

## Requirements
- R1: After reset, div_out and div_half are 0, both ratio registers hold 256 and the counter starts at 255. The first pulse follows 255 clocks after reset is released, and later pulses come every 256 clocks until a new ratio is transferred.
- R2: With a held ratio N in the range 17 to 32767, where N is the plain binary value of wr_ratio[14:0], consecutive div_out pulses are exactly N clocks apart.
- R3: div_out is high for exactly one clock per period.
- R4: A ratio written with wr_en just at a reload takes effect only after two more full periods at the old ratio. At the next reload it moves into the holding register, and at the reload after that it enters the counter.
- R5: A written ratio below 17, including 0, is transferred as 17. The holding register never holds a value below 17.
- R6: A rising edge on bus_start copies the staging register into the holding register mid-period. The running period keeps its length, and the following period uses the new ratio.
- R7: div_half inverts on the clock after every div_out pulse, so its period is 2N.
- R8: The holding register changes only at a reload or at a synchronized bus-start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled oscillator clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for the staging register |
| wr_ratio | input | 15 | Ratio data for the staging register |
| bus_start | input | 1 | Asynchronous bus start indication |
| div_out | output | 1 | One-clock pulse at each reload |
| div_half | output | 1 | Test output, div_out divided by two |

## Verification
Each result is due a known number of clocks after its stimulus. A pulse follows the previous pulse after exactly N clocks. div_half inverts one clock after a pulse. A write made at a reload shows up two periods later. A bus-start edge is acted on three clocks after it is asserted, and only the period after the current one changes. The bench drives inputs on falling edges and counts falling edges between pulses. Every interval is compared with the ratio expected for that period, which the bench works out from the write and transfer history.

// File: rtl/ratio_divider.sv
module ratio_divider #(
  parameter int WIDTH       = 15,
  parameter int MIN_RATIO   = 17,
  parameter int RESET_RATIO = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_ratio,
  input  logic             bus_start,
  output logic             div_out,
  output logic             div_half
);
  localparam logic [WIDTH-1:0] MIN_R = WIDTH'(MIN_RATIO);
  localparam logic [WIDTH-1:0] RST_R = WIDTH'(RESET_RATIO);

  logic [WIDTH-1:0] ratio_a, ratio_b, cnt;
  logic [2:0]       sync;

  wire              start_rise = sync[1] & ~sync[2];
  wire              reload     = (cnt == '0);
  wire [WIDTH-1:0]  a_clamped  = (ratio_a < MIN_R) ? MIN_R : ratio_a;

  assign div_out = reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_a  <= RST_R;
      ratio_b  <= RST_R;
      cnt      <= RST_R - 1'b1;
      sync     <= '0;
      div_half <= 1'b0;
    end else begin
      sync <= {sync[1:0], bus_start};
      if (wr_en) ratio_a <= wr_ratio;
      if (reload || start_rise) ratio_b <= a_clamped;
      if (reload) begin
        cnt      <= ratio_b - 1'b1;
        div_half <= ~div_half;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !div_out |=> cnt == $past(cnt) - 1'b1);

  assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_b >= MIN_R);

  assert_half_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> div_half != $past(div_half));

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_out && !start_rise) |=> $stable(ratio_b));
endmodule

// File: tb/ratio_divider_tb.sv
module ratio_divider_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [14:0] wr_ratio = '0;
  logic        bus_start = 0;
  logic        div_out, div_half;
  int          tests = 0, fails = 0, cycles = 0;
  int          prev, c;

  ratio_divider u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ratio(wr_ratio),
                       .bus_start(bus_start), .div_out(div_out), .div_half(div_half));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    logic h0;
    h0 = div_half;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      wr_en = 0;
      if (n == 1) begin
        chk(!div_out, "R3 pulse width", int'(div_out), 0);
        chk(div_half == !h0, "R7 half toggle", int'(div_half), int'(!h0));
      end
    end while (!div_out);
  endtask

  task automatic apply(input int n, input int exp, input string tag);
    wr_ratio = 15'(n);
    wr_en = 1;
    wait_pulse(c); chk(c == prev, "R4 old ratio kept 1", c, prev);
    wait_pulse(c); chk(c == prev, "R4 old ratio kept 2", c, prev);
    wait_pulse(c); chk(c == exp, tag, c, exp);
    prev = exp;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!div_out && !div_half, "R1 reset outputs", int'({div_out, div_half}), 0);
    rst_n = 1;
    c = 0;
    do begin @(negedge clk); c++; end while (!div_out);
    chk(c == 255, "R1 first pulse", c, 255);
    wait_pulse(c); chk(c == 256, "R1 reset ratio", c, 256);
    wait_pulse(c); chk(c == 256, "R1 reset ratio repeat", c, 256);
    prev = 256;

    for (int n = 17; n <= 40; n++) apply(n, n, "R2 ratio sweep");
    apply(5,  17, "R5 clamp 5");
    apply(0,  17, "R5 clamp 0");
    apply(16, 17, "R5 clamp 16");
    apply(300, 300, "R2 ratio 300");
    apply(1000, 1000, "R2 ratio 1000");

    wr_ratio = 15'd20;
    wr_en = 1;
    c = 0;
    do begin
      @(negedge clk);
      c++;
      wr_en = 0;
      bus_start = (c >= 100 && c < 103);
    end while (!div_out);
    chk(c == 1000, "R6 running period kept", c, 1000);
    wait_pulse(c); chk(c == 20, "R6 start transfer applied", c, 20);
    wait_pulse(c); chk(c == 20, "R8 ratio holds", c, 20);
    prev = 20;

    apply(32767, 32767, "R2 max ratio");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule